// File: doc/BRIEF.md
# NAND Chunk Hamming Parity Generator

This block builds a single-error-correcting Hamming code for one 512-byte chunk of NAND page data. Bytes are presented on an 8-bit bus with a one-cycle strobe. For each strobed byte the block updates twelve complementary parity pairs. Three column pairs are driven by the position of each bit inside its byte. Nine row pairs are driven by the byte's own parity together with its index in the chunk. The code is non-inverted, so a chunk of all-0xFF bytes yields zero. Software compares the code computed on read with the code stored in the spare area. The XOR of the two codes then tells it whether the chunk is clean, whether one bit can be corrected, or whether the error cannot be corrected.

A control interface takes a configuration word and a clear command. The configuration word carries an enable, a chip-select field and a bus-width flag. The bus-width flag is captured only. A small state machine controls accumulation. Its states are IDLE (accumulation off), ACCUM (bytes are folded in) and DONE (chunk complete, result frozen). Its transitions are:
- IDLE to ACCUM on a configuration write with enable set.
- ACCUM to IDLE on a configuration write with enable clear.
- ACCUM to DONE when the 512th byte is accepted.
- Any state to ACCUM or IDLE on a clear, chosen by the enable value.

The DONE state leaves only on a clear.

Top module: `nand_hecc_gen`

## Requirements
- R1: After reset, `ecc_result` and `ecc_code` are zero, `done` and `accum_on` are low, and `cs_sel` and `wide_bus` are zero.
- R2: A configuration write (`cfg_wr` high) captures the following fields of `cfg_data`, visible from the next cycle: bit 0 as enable, bits 3:1 as the chip select on `cs_sel`, and bit 7 as the bus-width flag on `wide_bus`. A write with bit 0 set moves IDLE to ACCUM, which raises `accum_on`.
- R3: Column parity: for k in 0..2, the "high" bit k is the XOR of every accepted data bit whose bit position has bit k set. The "low" bit k is the XOR of the data bits whose position has bit k clear.
- R4: Row parity: for j in 0..8, the "high" bit j is the XOR of the parities of accepted bytes whose index (0 to 511) has bit j set. The "low" bit j covers the bytes whose index has bit j clear.
- R5: `ecc_result` layout: [2:0] holds the column-low bits and [11:3] the row-low bits. [18:16] holds the column-high bits and [27:19] the row-high bits. Bits [15:12] and [31:28] are zero. Each strobe accepted in ACCUM is reflected in `ecc_result` on the following cycle.
- R6: `ecc_code` = {`ecc_result`[27:24], `ecc_result`[11:8], `ecc_result`[23:16], `ecc_result`[7:0]}. This is three bytes, with the first byte in bits 7:0.
- R7: A full chunk of 0xFF bytes gives `ecc_result` = 0 and `ecc_code` = 0.
- R8: When the 512th byte is accepted, `done` rises and `accum_on` falls. From then on, strobes and configuration writes leave `ecc_result` unchanged and `done` stays high until a clear.
- R9: A clear (`clr` high) zeroes the parities and the byte count and drops `done`. The next state is ACCUM if enable is set and IDLE otherwise. A strobe in the same cycle as a clear is dropped.
- R10: A configuration write with bit 0 clear, issued in ACCUM, stops accumulation. Later strobes leave `ecc_result` unchanged, and the partial result is kept. Re-enabling resumes at the next byte index.
- R11: If two chunks differ in a single data bit, their results differ in exactly 12 bits. Bits [27:16] of that difference equal byte_index*8 + bit_index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration word: enable, chip select, bus width |
| clr | input | 1 | Clear parities, count and done |
| byte_stb | input | 1 | Data byte valid |
| byte_data | input | 8 | Data byte |
| ecc_result | output | 32 | Packed parity halves |
| ecc_code | output | 24 | Three-byte code formed from the result |
| done | output | 1 | Chunk complete, result frozen |
| accum_on | output | 1 | State machine is in ACCUM |
| cs_sel | output | 3 | Captured chip-select field |
| wide_bus | output | 1 | Captured bus-width flag |

## Verification
The assertions assume that `clr`, `cfg_wr` and `byte_stb` are clean one-cycle pulses sampled at the rising edge, and that clear takes priority over any strobe in the same cycle. The bench changes every input only at the falling edge and holds each strobe for exactly one cycle. It issues clears and configuration writes only between bytes, except where a requirement calls for an overlap. Each chunk's expected code is queued before its bytes are sent, so the monitor always has an entry ready when `done` rises.

// File: rtl/nhe_pkg.sv
`timescale 1ns/1ps
package nhe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } nhe_state_e;

    localparam int RES_W    = 32;
    localparam int CODE_W   = 24;
    localparam int HI_OFS   = 16;
    localparam int CFG_W    = 8;
    localparam int EN_BIT   = 0;
    localparam int WIDE_BIT = 7;
endpackage

// File: rtl/nhe_ctrl_fsm.sv
`timescale 1ns/1ps
module nhe_ctrl_fsm
    import nhe_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int CS_W        = 3,
    localparam int ROW_BITS   = $clog2(CHUNK_BYTES),
    localparam int CNT_W      = ROW_BITS + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_en,
    input  logic [CS_W-1:0]     cfg_cs,
    input  logic                cfg_wide,
    input  logic                clr,
    input  logic                byte_stb,
    output logic                accept,
    output logic                par_clr,
    output logic [ROW_BITS-1:0] byte_idx,
    output logic                done,
    output logic                accum_on,
    output logic [CS_W-1:0]     cs_sel,
    output logic                wide_bus
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHUNK_BYTES - 1);

    nhe_state_e state_q, state_d;
    logic              en_q, en_d;
    logic [CS_W-1:0]   cs_q;
    logic              wide_q;
    logic [CNT_W-1:0]  cnt_q;

    // Enable value seen after this cycle's configuration write
    assign en_d = cfg_wr ? cfg_en : en_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = en_d ? ST_ACCUM : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_wr && cfg_en) state_d = ST_ACCUM;
                end
                ST_ACCUM: begin
                    if (byte_stb && (cnt_q == LAST_IDX)) state_d = ST_DONE;
                    else if (cfg_wr && !cfg_en)          state_d = ST_IDLE;
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cs_q   <= '0;
            wide_q <= 1'b0;
        end else if (cfg_wr) begin
            en_q   <= cfg_en;
            cs_q   <= cfg_cs;
            wide_q <= cfg_wide;
        end
    end

    // Byte counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    // Outputs
    always_comb begin
        accept   = 1'b0;
        done     = 1'b0;
        accum_on = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ACCUM: begin
                accum_on = 1'b1;
                accept   = byte_stb && !clr;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
        par_clr  = clr;
        byte_idx = cnt_q[ROW_BITS-1:0];
        cs_sel   = cs_q;
        wide_bus = wide_q;
    end
endmodule

// File: rtl/nhe_col_parity.sv
`timescale 1ns/1ps
module nhe_col_parity #(
    parameter int DATA_W    = 8,
    localparam int COL_BITS = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                accept,
    input  logic [DATA_W-1:0]   data,
    output logic [COL_BITS-1:0] col_hi,
    output logic [COL_BITS-1:0] col_lo
);
    function automatic logic [DATA_W-1:0] pos_mask(input int k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) m[i] = ((i >> k) & 1) != 0;
        return m;
    endfunction

    logic [COL_BITS-1:0] hi_fold, lo_fold;

    genvar k;
    generate
        for (k = 0; k < COL_BITS; k++) begin : g_col
            localparam logic [DATA_W-1:0] MASK_HI = pos_mask(k);
            assign hi_fold[k] = ^(data & MASK_HI);
            assign lo_fold[k] = ^(data & ~MASK_HI);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_hi <= '0;
            col_lo <= '0;
        end else if (clr) begin
            col_hi <= '0;
            col_lo <= '0;
        end else if (accept) begin
            col_hi <= col_hi ^ hi_fold;
            col_lo <= col_lo ^ lo_fold;
        end
    end
endmodule

// File: rtl/nhe_row_parity.sv
`timescale 1ns/1ps
module nhe_row_parity #(
    parameter int ROW_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                accept,
    input  logic                byte_par,
    input  logic [ROW_BITS-1:0] byte_idx,
    output logic [ROW_BITS-1:0] row_hi,
    output logic [ROW_BITS-1:0] row_lo
);
    logic [ROW_BITS-1:0] hi_fold, lo_fold;

    genvar j;
    generate
        for (j = 0; j < ROW_BITS; j++) begin : g_row
            assign hi_fold[j] = byte_par &  byte_idx[j];
            assign lo_fold[j] = byte_par & ~byte_idx[j];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_hi <= '0;
            row_lo <= '0;
        end else if (clr) begin
            row_hi <= '0;
            row_lo <= '0;
        end else if (accept) begin
            row_hi <= row_hi ^ hi_fold;
            row_lo <= row_lo ^ lo_fold;
        end
    end
endmodule

// File: rtl/nhe_pack.sv
`timescale 1ns/1ps
module nhe_pack
    import nhe_pkg::*;
#(
    parameter int COL_BITS = 3,
    parameter int ROW_BITS = 9,
    localparam int HALF    = COL_BITS + ROW_BITS
) (
    input  logic [COL_BITS-1:0] col_hi,
    input  logic [COL_BITS-1:0] col_lo,
    input  logic [ROW_BITS-1:0] row_hi,
    input  logic [ROW_BITS-1:0] row_lo,
    output logic [RES_W-1:0]    result,
    output logic [CODE_W-1:0]   code
);
    // The three-byte code needs 12-bit halves placed 16 bits apart
    always_comb begin
        result                = '0;
        result[HALF-1:0]      = {row_lo, col_lo};
        result[HI_OFS +: HALF] = {row_hi, col_hi};
    end

    assign code = {result[27:24], result[11:8], result[23:16], result[7:0]};
endmodule

// File: rtl/nand_hecc_gen.sv
`timescale 1ns/1ps
module nand_hecc_gen
    import nhe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 512,
    parameter int CS_W        = 3,
    localparam int COL_BITS   = $clog2(DATA_W),
    localparam int ROW_BITS   = $clog2(CHUNK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              clr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    output logic [RES_W-1:0]  ecc_result,
    output logic [CODE_W-1:0] ecc_code,
    output logic              done,
    output logic              accum_on,
    output logic [CS_W-1:0]   cs_sel,
    output logic              wide_bus
);
    logic                accept;
    logic                par_clr;
    logic [ROW_BITS-1:0] byte_idx;
    logic [COL_BITS-1:0] col_hi, col_lo;
    logic [ROW_BITS-1:0] row_hi, row_lo;
    logic                unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_data[WIDE_BIT-1:CS_W+1];

    nhe_ctrl_fsm #(
        .CHUNK_BYTES(CHUNK_BYTES),
        .CS_W       (CS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_en   (cfg_data[EN_BIT]),
        .cfg_cs   (cfg_data[CS_W:1]),
        .cfg_wide (cfg_data[WIDE_BIT]),
        .clr      (clr),
        .byte_stb (byte_stb),
        .accept   (accept),
        .par_clr  (par_clr),
        .byte_idx (byte_idx),
        .done     (done),
        .accum_on (accum_on),
        .cs_sel   (cs_sel),
        .wide_bus (wide_bus)
    );

    nhe_col_parity #(.DATA_W(DATA_W)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (par_clr),
        .accept (accept),
        .data   (byte_data),
        .col_hi (col_hi),
        .col_lo (col_lo)
    );

    nhe_row_parity #(.ROW_BITS(ROW_BITS)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (par_clr),
        .accept   (accept),
        .byte_par (^byte_data),
        .byte_idx (byte_idx),
        .row_hi   (row_hi),
        .row_lo   (row_lo)
    );

    nhe_pack #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_pack (
        .col_hi (col_hi),
        .col_lo (col_lo),
        .row_hi (row_hi),
        .row_lo (row_lo),
        .result (ecc_result),
        .code   (ecc_code)
    );
endmodule

// File: rtl/nhe_sva.sv
`timescale 1ns/1ps
module nhe_sva #(
    parameter int CS_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_wr,
    input logic            cfg_en,
    input logic [CS_W-1:0] cfg_cs,
    input logic            clr,
    input logic [31:0]     ecc_result,
    input logic            done,
    input logic            accum_on,
    input logic [CS_W-1:0] cs_sel
);
    AST_CFG_CS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cs_sel == $past(cfg_cs)); // R2

    AST_ENABLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !accum_on && cfg_wr && cfg_en && !clr) |=> accum_on); // R2

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> ($stable(ecc_result) && done)); // R8

    AST_DONE_NOT_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && accum_on)); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ecc_result == 32'h0 && !done)); // R9

    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_on && cfg_wr && !cfg_en && !clr) |=> !accum_on); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!accum_on && !done && !clr) |=> $stable(ecc_result)); // R10
endmodule

bind nand_hecc_gen nhe_sva #(.CS_W(CS_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_en     (cfg_data[0]),
    .cfg_cs     (cfg_data[CS_W:1]),
    .clr        (clr),
    .ecc_result (ecc_result),
    .done       (done),
    .accum_on   (accum_on),
    .cs_sel     (cs_sel)
);

// File: tb/sim_nand_hecc_gen.sv
`timescale 1ns/1ps
module sim_nand_hecc_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_data;
    logic        clr;
    logic        byte_stb;
    logic [7:0]  byte_data;
    logic [31:0] ecc_result;
    logic [23:0] ecc_code;
    logic        done;
    logic        accum_on;
    logic [2:0]  cs_sel;
    logic        wide_bus;

    always #2.5 clk = ~clk;

    nand_hecc_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .clr(clr), .byte_stb(byte_stb), .byte_data(byte_data),
        .ecc_result(ecc_result), .ecc_code(ecc_code), .done(done),
        .accum_on(accum_on), .cs_sel(cs_sel), .wide_bus(wide_bus)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [7:0]  mem [512];
    logic [31:0] exp_q [$];
    logic        prev_done = 1'b0;

    // Requirement-level model of the packed parity (R3, R4, R5)
    function automatic logic [31:0] model(input int n);
        logic [2:0] ch, cl;
        logic [8:0] rh, rl, bi;
        ch = '0; cl = '0; rh = '0; rl = '0;
        for (int b = 0; b < n; b++) begin
            bi = b[8:0];
            for (int i = 0; i < 8; i++)
                if (mem[b][i])
                    for (int k = 0; k < 3; k++)
                        if (((i >> k) & 1) != 0) ch[k] = ~ch[k];
                        else                     cl[k] = ~cl[k];
            if (^mem[b]) begin
                rh = rh ^ bi;
                rl = rl ^ ~bi;
            end
        end
        return {4'h0, rh, ch, 4'h0, rl, cl};
    endfunction

    function automatic logic [23:0] code_of(input logic [31:0] r);
        return {r[27:24], r[11:8], r[23:16], r[7:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic feed(input int from, input int upto);
        for (int b = from; b <= upto; b++) push_byte(mem[b]);
    endtask

    // Scoreboard monitor: pops the expected code when a chunk completes
    always @(negedge clk) begin
        if (done && !prev_done) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected done", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R3 R4 chunk result", ecc_result, e);
                check("R6 chunk code", {8'h0, ecc_code}, {8'h0, code_of(e)});
            end
        end
        prev_done = done;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] hold, ra, rb, diff;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0; clr = 1'b0;
        byte_stb = 1'b0; byte_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        check("R1 result", ecc_result, 32'h0);
        check("R1 code", {8'h0, ecc_code}, 32'h0);
        check("R1 flags", {29'h0, done, accum_on, wide_bus}, 32'h0);
        check("R1 cs", {29'h0, cs_sel}, 32'h0);

        // R2: enable=1, cs=5, wide=1
        do_cfg(8'h8B);
        check("R2 cs", {29'h0, cs_sel}, 32'h5);
        check("R2 wide", {31'h0, wide_bus}, 32'h1);
        check("R2 accum", {31'h0, accum_on}, 32'h1);

        for (int b = 0; b < 512; b++) mem[b] = 8'($urandom);
        mem[0] = 8'h01; mem[1] = 8'h80; mem[2] = 8'h3C;

        push_byte(mem[0]);
        check("R3 R4 R5 first byte", ecc_result, 32'h0000_0FFF);
        push_byte(mem[1]);
        check("R3 R4 second byte", ecc_result, 32'h000F_000F);
        check("R6 code packing", {8'h0, ecc_code}, 32'h0000_0F0F);
        push_byte(mem[2]);
        check("R5 partial model", ecc_result, model(3));

        // R10: disable, strobes ignored, then resume
        do_cfg(8'h0A);
        hold = ecc_result;
        push_byte(8'h55);
        push_byte(8'hE7);
        check("R10 held while disabled", ecc_result, hold);
        check("R10 accum off", {31'h0, accum_on}, 32'h0);
        do_cfg(8'h8B);
        exp_q.push_back(model(512));
        feed(3, 511);
        check("R8 done raised", {30'h0, done, accum_on}, 32'h2);

        // R8: strobes after done ignored
        hold = ecc_result;
        push_byte(8'h01);
        push_byte(8'hFE);
        do_cfg(8'h8B);
        check("R8 frozen result", ecc_result, hold);
        check("R8 done kept", {31'h0, done}, 32'h1);

        // R9
        do_clear();
        check("R9 cleared result", ecc_result, 32'h0);
        check("R9 flags after clear", {30'h0, done, accum_on}, 32'h1);

        // R7: erased chunk
        for (int b = 0; b < 512; b++) mem[b] = 8'hFF;
        exp_q.push_back(model(512));
        feed(0, 511);
        check("R7 erased result", ecc_result, 32'h0);
        check("R7 erased code", {8'h0, ecc_code}, 32'h0);
        check("R7 done", {31'h0, done}, 32'h1);

        // R11: single bit flip locates the error
        do_clear();
        for (int b = 0; b < 512; b++) mem[b] = 8'($urandom);
        exp_q.push_back(model(512));
        feed(0, 511);
        ra = ecc_result;
        do_clear();
        mem[300] = mem[300] ^ 8'h20;
        exp_q.push_back(model(512));
        feed(0, 511);
        rb = ecc_result;
        diff = ra ^ rb;
        check("R11 weight", 32'($countones(diff)), 32'd12);
        check("R11 position", {20'h0, diff[27:16]}, 32'd2405);

        // R9: clear while disabled lands in IDLE
        do_cfg(8'h00);
        do_clear();
        check("R9 clear disabled", {30'h0, done, accum_on}, 32'h0);
        check("R9 result zero", ecc_result, 32'h0);

        repeat (3) @(negedge clk);
        check("R8 queue drained", 32'(exp_q.size()), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule